// File: doc/BRIEF.md
# Paged Flash Write/Erase Controller

This block sits on the CPU data-space write path and decides where each write lands. With its program-enable control bit clear, a write strobe stores the byte into ordinary RAM. With the bit set, the write is turned into an operation on a modelled nonvolatile byte array. It is a byte program when the erase-enable bit is clear, and a whole-page erase when both bits are set.

Nonvolatile operations go ahead only while the lock sequencer asserts its grant. The operation then runs for a fixed number of clock cycles, and the CPU is held through a stall output instead of polling for completion. When each operation finishes, a one-cycle done pulse tells the lock sequencer to lock again. A combinational read port returns bytes from either the RAM or the array.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset, every array byte reads 0xFF, `stall` and `op_done` are low, and `ctl_q` is 00.
- R2: A write strobe with `ctl_q[0]`=0 stores `wr_data` into RAM at `wr_addr` mod RAM_BYTES. It raises no stall and leaves the array unchanged.
- R3: A write strobe with `ctl_q`=01 and the grant high programs array byte `wr_addr` mod FLASH_BYTES. The byte becomes its old value AND `wr_data`, so bits can only go from 1 to 0.
- R4: A write strobe with `ctl_q`=11 and the grant high erases the page that holds the addressed byte. Every byte of that page becomes 0xFF, and `wr_data` has no effect.
- R5: A page is PAGE_BYTES (512) consecutive bytes selected by array index / 512. Any address inside a page selects it, and bytes of other pages are unchanged by its erase.
- R6: `ctl_q` is written only by `ctl_we` (bit 0 program enable, bit 1 erase enable). The program-enable bit stays set across any number of operations until software writes it to 0.
- R7: `stall` rises in the cycle after an operation is accepted. It stays high for exactly PROG_CYC (4) cycles for a program, or ERASE_CYC (32) cycles for an erase, and the array shows the new contents once `stall` falls.
- R8: A write to the array while the grant is low is dropped: no stall, no done pulse, no array change.
- R9: `op_done` is high for exactly one cycle: the first cycle after `stall` falls.
- R10: Write strobes that arrive while `stall` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control value: bit 0 program enable, bit 1 erase enable |
| ctl_q | output | 2 | Current control register value |
| wr_addr | input | ADDR_W | Data-space write address |
| wr_data | input | 8 | Write data byte |
| wr_stb | input | 1 | Write strobe |
| unlock_grant | input | 1 | Lock sequencer permits one operation |
| stall | output | 1 | CPU hold while an operation runs |
| op_done | output | 1 | One-cycle pulse when an operation finishes |
| rd_sel | input | 1 | Read source: 1 array, 0 RAM |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
A strobe sampled at edge E sets `stall` by E+1. For a program it falls at E+4, and for an erase at E+32. `op_done` and the new array contents are visible from that same falling edge, and RAM writes are visible right after E. The driver counts stall cycles at falling clock edges and checks `op_done` at the edge where `stall` drops and again one cycle later. It queues expected read values only after the operation has finished, and the monitor compares them through the combinational read port. The queue is drained before the next operation can change the array.

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int FLASH_BYTES = 1024,
  parameter int PAGE_BYTES  = 512,
  parameter int RAM_BYTES   = 256,
  parameter int PROG_CYC    = 4,
  parameter int ERASE_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_wdata,
  output logic [1:0]        ctl_q,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_stb,
  input  logic              unlock_grant,
  output logic              stall,
  output logic              op_done,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int FA_W  = $clog2(FLASH_BYTES);
  localparam int RA_W  = $clog2(RAM_BYTES);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [7:0] flash_mem [FLASH_BYTES];
  logic [7:0] ram_mem   [RAM_BYTES];

  logic             busy;
  logic             op_erase;
  logic [FA_W-1:0]  op_idx;
  logic [7:0]       op_data;
  logic [CNT_W-1:0] cnt;

  wire wr_go  = wr_stb && !busy;
  wire accept = wr_go && ctl_q[0] && unlock_grant;
  wire finish = busy && (cnt == CNT_W'(1));

  logic unused_hi;
  assign unused_hi = ^{wr_addr[ADDR_W-1:FA_W], rd_addr[ADDR_W-1:FA_W]};

  assign stall   = busy;
  assign rd_data = rd_sel ? flash_mem[rd_addr[FA_W-1:0]] : ram_mem[rd_addr[RA_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= 2'b00;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_go && !ctl_q[0]) ram_mem[wr_addr[RA_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      op_erase <= 1'b0;
      op_idx   <= '0;
      op_data  <= '0;
      op_done  <= 1'b0;
    end else begin
      op_done <= finish;
      if (accept) begin
        busy     <= 1'b1;
        op_erase <= ctl_q[1];
        op_idx   <= wr_addr[FA_W-1:0];
        op_data  <= wr_data;
        cnt      <= ctl_q[1] ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (finish) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FLASH_BYTES; i++) flash_mem[i] <= 8'hFF;
    end else if (finish) begin
      if (op_erase) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          flash_mem[{op_idx[FA_W-1:PG_W], PG_W'(i)}] <= 8'hFF;
      end else begin
        flash_mem[op_idx] <= flash_mem[op_idx] & op_data;
      end
    end
  end
endmodule

module flash_wr_ctrl_chk #(
  parameter int ERASE_CYC = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [1:0] ctl_q,
  input logic       wr_stb,
  input logic       unlock_grant,
  input logic       stall,
  input logic       op_done
);
  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n)     run <= '0;
    else if (stall) run <= run + 16'd1;
    else            run <= '0;
  end

  AST_RAM_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !stall && !ctl_q[0] |=> !stall);                          // R2
  AST_WREN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we && ctl_q[0] |=> ctl_q[0]);                                   // R6
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !stall && ctl_q[0] && unlock_grant |=> stall);             // R7
  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(ERASE_CYC));                                              // R7
  AST_NO_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !stall && ctl_q[0] && !unlock_grant |=> !stall);           // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> op_done);                                           // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);                                               // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !stall);                                                 // R9
endmodule

bind flash_wr_ctrl flash_wr_ctrl_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_q(ctl_q), .wr_stb(wr_stb),
  .unlock_grant(unlock_grant), .stall(stall), .op_done(op_done));

// File: tb/tb_flash_wr_ctrl.sv
module tb_flash_wr_ctrl;
  localparam int AW = 16, FB = 1024, PB = 512, RB = 256, PC = 4, EC = 32;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0; logic [1:0] ctl_wdata = 0; logic [1:0] ctl_q;
  logic [AW-1:0] wr_addr = 0; logic [7:0] wr_data = 0; logic wr_stb = 0;
  logic unlock_grant = 0, stall, op_done;
  logic rd_sel = 0; logic [AW-1:0] rd_addr = 0; logic [7:0] rd_data;

  flash_wr_ctrl #(.ADDR_W(AW), .FLASH_BYTES(FB), .PAGE_BYTES(PB), .RAM_BYTES(RB),
                  .PROG_CYC(PC), .ERASE_CYC(EC)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { bit sel; int addr; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  logic [7:0] fm [FB];
  logic [7:0] rm [RB];
  int vecs = 0, fails = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      rd_sel = it.sel; rd_addr = AW'(it.addr);
      #1 chk(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
    end
  end

  task automatic expect_rd(bit sel, int a, string tag);
    item_t it;
    it.sel = sel; it.addr = a; it.tag = tag;
    it.exp = sel ? fm[a % FB] : rm[a % RB];
    q.push_back(it);
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0);
    #3;
  endtask

  task automatic set_ctl(logic [1:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
    chk(ctl_q === v, "R6 ctl write", int'(ctl_q), int'(v));
  endtask

  task automatic ram_wr(int a, logic [7:0] d);
    @(negedge clk); wr_addr = AW'(a); wr_data = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    chk(stall === 1'b0, "R2 ram write no stall", int'(stall), 0);
    rm[a % RB] = d;
  endtask

  task automatic flash_op(int a, logic [7:0] d, bit go, int exp_cyc, string tag, bit intrude);
    int n;
    @(negedge clk); wr_addr = AW'(a); wr_data = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    if (!go) begin
      chk(stall === 1'b0, {tag, " dropped no stall"}, int'(stall), 0);
      @(negedge clk);
      chk(op_done === 1'b0, {tag, " dropped no done"}, int'(op_done), 0);
      return;
    end
    n = 0;
    while (stall === 1'b1 && n < 100) begin
      n++;
      if (intrude && n == 2) begin
        wr_addr = AW'(768); wr_data = 8'h00; wr_stb = 1;
      end else wr_stb = 0;
      @(negedge clk);
    end
    wr_stb = 0;
    chk(n == exp_cyc, {tag, " R7 stall length"}, n, exp_cyc);
    chk(op_done === 1'b1, {tag, " R9 done at stall fall"}, int'(op_done), 1);
    @(negedge clk);
    chk(op_done === 1'b0, {tag, " R9 done one cycle"}, int'(op_done), 0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < FB; i++) fm[i] = 8'hFF;
    for (int i = 0; i < RB; i++) rm[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(stall === 1'b0, "R1 stall after reset", int'(stall), 0);
    chk(op_done === 1'b0, "R1 done after reset", int'(op_done), 0);
    chk(ctl_q === 2'b00, "R1 ctl after reset", int'(ctl_q), 0);
    expect_rd(1, 0, "R1 flash 0"); expect_rd(1, 511, "R1 flash 511");
    expect_rd(1, 512, "R1 flash 512"); expect_rd(1, 1023, "R1 flash 1023");
    drain();

    ram_wr(16'h0010, 8'h3C);
    ram_wr(16'h01F1, 8'hC5);
    expect_rd(0, 16'h0010, "R2 ram data"); expect_rd(0, 16'h01F1, "R2 ram wrapped");
    expect_rd(1, 16'h0010, "R2 flash untouched");
    drain();

    unlock_grant = 1;
    set_ctl(2'b01);
    flash_op(16'h0020, 8'hA5, 1, PC, "R3 prog1", 0);
    fm[16'h20] = fm[16'h20] & 8'hA5;
    expect_rd(1, 16'h0020, "R3 prog value"); expect_rd(0, 16'h0020, "R3 ram untouched");
    drain();
    flash_op(16'h0020, 8'h0F, 1, PC, "R6 prog2 no ctl rewrite", 0);
    fm[16'h20] = fm[16'h20] & 8'h0F;
    chk(ctl_q === 2'b01, "R6 wren still set", int'(ctl_q), 1);
    expect_rd(1, 16'h0020, "R3 and-merge");
    drain();
    flash_op(16'h0020, 8'hFF, 1, PC, "R3 prog ones", 0);
    expect_rd(1, 16'h0020, "R3 cannot set bits");
    drain();
    flash_op(16'h0205, 8'h12, 1, PC, "R5 prog page1", 0);
    fm[16'h205] = 8'h12;
    flash_op(16'h05FF, 8'h3E, 1, PC, "R3 prog aliased", 0);
    fm[16'h1FF] = 8'h3E;
    expect_rd(1, 16'h0205, "R5 page1 byte"); expect_rd(1, 16'h01FF, "R3 aliased byte");
    drain();

    unlock_grant = 0;
    flash_op(16'h0030, 8'h00, 0, 0, "R8 prog", 0);
    expect_rd(1, 16'h0030, "R8 byte unchanged");
    drain();

    unlock_grant = 1;
    set_ctl(2'b11);
    flash_op(16'h0123, 8'h00, 1, EC, "R4 erase", 1);
    for (int i = 0; i < PB; i++) fm[i] = 8'hFF;
    expect_rd(1, 16'h0020, "R4 erased byte"); expect_rd(1, 16'h01FF, "R4 erased last");
    expect_rd(1, 16'h0000, "R4 erased first");
    expect_rd(1, 16'h0205, "R5 other page kept");
    expect_rd(1, 16'h0300, "R10 write during stall ignored");
    drain();

    unlock_grant = 0;
    flash_op(16'h0205, 8'h00, 0, 0, "R8 erase", 0);
    expect_rd(1, 16'h0205, "R8 erase dropped");
    drain();

    unlock_grant = 1;
    set_ctl(2'b00);
    ram_wr(16'h0044, 8'h77);
    expect_rd(0, 16'h0044, "R6 cleared wren routes to ram");
    expect_rd(1, 16'h0044, "R2 flash untouched after clear");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule